// File: doc/BRIEF.md
# Address Translation Mode Front End

This block sits ahead of the TLB in a load/store and fetch pipeline and decides how each virtual address is turned into a physical one. It tries three local resolutions, in a fixed order. First is a direct-address mode that passes the address straight through. Next is a bank of direct-map windows gated by privilege level. Last is a sign-extension check on the bits above the virtual space. An address that none of these resolves is handed to an external TLB through a request/response port.

When the local logic or the TLB has produced a result, the block registers a one-cycle `done` pulse. With it come the physical address and read/write/execute grant bits, or an exception code chosen from the fault kind and the access type. The same cycle carries the write strobes and data for the software-visible capture registers: the refill bad-address and refill page-pair number on a TLB miss, and the general bad-address and entry-high values on every other fault.

A request is accepted only when the block is idle. A request that the TLB must resolve keeps the block busy until the TLB answers.

Top module: `xlat_front`

## Requirements
- R1: After synchronous reset, `done`, `busy`, `tlb_req`, `exc_valid`, `refill_set`, `refill_badv_we`, `badv_we` and `ehi_we` are all 0.
- R2: With `mode_da`=1 and `mode_pg`=0, an accepted request completes with `done`=1 in the cycle after acceptance. It makes no TLB request, `pa_out` is `req_vaddr[PA_W-1:0]`, `grant` is 3'b111 (bit 2 read, bit 1 write, bit 0 execute) and `exc_valid` is 0. The other three mode combinations do not select this pass-through.
- R3: Otherwise each window is a 64-bit slice of `win_cfg`, with window i at bits [64*i+63:64*i]. Bit 0 enables the window for privilege 0 and bit 3 enables it for privilege 3. Privilege levels 1 and 2 never use a window. A window matches when it is enabled for `req_priv` and its bits [63:48] equal `req_vaddr[63:48]`. A match completes the request in the next cycle without a TLB request, with `grant`=3'b111 and `pa_out`=`req_vaddr[47:0]`.
- R4: If no window matches and `req_vaddr[63:48]` is neither all zeros nor all ones, the request completes in the next cycle as a bad address, without a TLB request. `exc_code` is 1 for a fetch and 2 for any other access.
- R5: Any other request pulses `tlb_req` for one cycle, carrying `tlb_vaddr`=`req_vaddr` and `tlb_acc`=`req_acc`. `done` rises in the cycle after `tlb_rsp_valid` is sampled high. Response code 0 is a hit, and it returns `pa_out`=`tlb_rsp_paddr` and `grant`=`tlb_rsp_grant`.
- R6: Access types are encoded 0 load, 1 store, 2 fetch; 3 is treated as a load. TLB codes 1 (no entry) and 2 (entry invalid) both give `exc_code` 3 for a load, 4 for a store and 5 for a fetch.
- R7: The remaining TLB codes map as follows: 3 (not dirty) gives `exc_code` 6, 4 (read inhibited) gives 7, 5 (execute inhibited) gives 8, and 6 (privilege) gives 9. Code 7 is reserved and is reported as a bad address under the R4 rule.
- R8: On TLB code 1, `refill_set` and `refill_badv_we` pulse with `done`. `refill_badv` is the address and `refill_vppn` is address bits [47:13]. `badv_we` and `ehi_we` stay 0.
- R9: On every other fault, including a bad address, `ehi_we` pulses with `ehi` equal to the address with bits [12:0] cleared. `badv_we` pulses with `badv` equal to the address unless `dbg_hold` is 1 in the completion cycle. `refill_set` and `refill_badv_we` stay 0.
- R10: A faulting completion has `exc_valid`=1, `grant`=0 and `pa_out`=0. A successful completion has `exc_valid`=0 and `exc_code`=0.
- R11: While `busy`=1, `req_valid` is ignored: no completion is produced for it and `tlb_vaddr` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | ADDR_W | Virtual address |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Privilege level 0..3 |
| mode_da | input | 1 | Direct-address mode bit |
| mode_pg | input | 1 | Paging mode bit |
| win_cfg | input | NWIN*ADDR_W | Direct-map window registers |
| dbg_hold | input | 1 | Suppresses the bad-address capture |
| busy | output | 1 | Waiting for the TLB |
| tlb_req | output | 1 | One-cycle TLB lookup request |
| tlb_vaddr | output | ADDR_W | Address sent to the TLB |
| tlb_acc | output | 2 | Access type sent to the TLB |
| tlb_rsp_valid | input | 1 | TLB result valid |
| tlb_rsp_code | input | 3 | TLB result code |
| tlb_rsp_paddr | input | PA_W | TLB physical address |
| tlb_rsp_grant | input | 3 | TLB read/write/execute grant |
| done | output | 1 | Completion pulse |
| pa_out | output | PA_W | Physical address |
| grant | output | 3 | Read/write/execute grant |
| exc_valid | output | 1 | Completion is a fault |
| exc_code | output | 4 | Exception code |
| refill_set | output | 1 | Set the refill-in-progress flag |
| refill_badv_we | output | 1 | Refill capture write strobe |
| refill_badv | output | ADDR_W | Refill bad address |
| refill_vppn | output | VA_W-13 | Refill page-pair number |
| badv_we | output | 1 | Bad-address register write strobe |
| badv | output | ADDR_W | Bad address |
| ehi_we | output | 1 | Entry-high write strobe |
| ehi | output | ADDR_W | Entry-high value |

## Verification
The assertions watch the following on every cycle:
- the TLB request is a single-cycle pulse and never coincides with a completion;
- a faulting completion carries no grant;
- refill captures and general fault captures never fire together;
- direct-address mode always completes one cycle after acceptance with full grant.

The priority between the local paths, the exact mapping from fault kind and access type to exception code, and the window gating by privilege level are shown only by the bench sweeps. The same holds for the debug suppression of the bad-address capture and for requests ignored while busy.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [2:0] {
    K_OK      = 3'd0,
    K_BAD     = 3'd1,
    K_NOMATCH = 3'd2,
    K_INVALID = 3'd3,
    K_DIRTY   = 3'd4,
    K_RINH    = 3'd5,
    K_XINH    = 3'd6,
    K_PRIV    = 3'd7
  } kind_e;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [3:0] EX_NONE      = 4'd0;
  localparam logic [3:0] EX_ADR_FETCH = 4'd1;
  localparam logic [3:0] EX_ADR_MEM   = 4'd2;
  localparam logic [3:0] EX_PI_LOAD   = 4'd3;
  localparam logic [3:0] EX_PI_STORE  = 4'd4;
  localparam logic [3:0] EX_PI_FETCH  = 4'd5;
  localparam logic [3:0] EX_MODIFY    = 4'd6;
  localparam logic [3:0] EX_NO_READ   = 4'd7;
  localparam logic [3:0] EX_NO_EXEC   = 4'd8;
  localparam logic [3:0] EX_PRIV      = 4'd9;

  // TLB result code to internal fault kind; code 7 is reserved.
  function automatic kind_e tlb_to_kind(input logic [2:0] code);
    case (code)
      3'd0:    return K_OK;
      3'd1:    return K_NOMATCH;
      3'd2:    return K_INVALID;
      3'd3:    return K_DIRTY;
      3'd4:    return K_RINH;
      3'd5:    return K_XINH;
      3'd6:    return K_PRIV;
      default: return K_BAD;
    endcase
  endfunction

endpackage

// File: rtl/xlat_win_match.sv
module xlat_win_match #(
  parameter int NWIN     = 4,
  parameter int ADDR_W   = 64,
  parameter int VA_W     = 48,
  parameter int EN_K_BIT = 0,
  parameter int EN_U_BIT = 3
) (
  input  logic [NWIN*ADDR_W-1:0] win_cfg,
  input  logic [ADDR_W-1:0]      vaddr,
  input  logic [1:0]             priv,
  output logic [NWIN-1:0]        hit,
  output logic                   hit_any
);
  localparam int TAG_W = ADDR_W - VA_W;

  logic use_k, use_u;
  assign use_k = (priv == 2'd0);
  assign use_u = (priv == 2'd3);

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [ADDR_W-1:0] w;
    logic              en;
    assign w  = win_cfg[i*ADDR_W +: ADDR_W];
    assign en = (use_k & w[EN_K_BIT]) | (use_u & w[EN_U_BIT]);
    assign hit[i] = en && (w[ADDR_W-1 -: TAG_W] == vaddr[ADDR_W-1 -: TAG_W]);
  end

  assign hit_any = |hit;

endmodule

// File: rtl/xlat_exc_map.sv
module xlat_exc_map
  import xlat_pkg::*;
(
  input  kind_e      kind,
  input  logic [1:0] acc,
  output logic [3:0] exc_code,
  output logic       fault,
  output logic       refill
);
  logic [3:0] pi_code;

  always_comb begin
    case (acc)
      ACC_STORE: pi_code = EX_PI_STORE;
      ACC_FETCH: pi_code = EX_PI_FETCH;
      default:   pi_code = EX_PI_LOAD;
    endcase
  end

  always_comb begin
    fault  = (kind != K_OK);
    refill = (kind == K_NOMATCH);
    case (kind)
      K_OK:      exc_code = EX_NONE;
      K_NOMATCH: exc_code = pi_code;
      K_INVALID: exc_code = pi_code;
      K_DIRTY:   exc_code = EX_MODIFY;
      K_RINH:    exc_code = EX_NO_READ;
      K_XINH:    exc_code = EX_NO_EXEC;
      K_PRIV:    exc_code = EX_PRIV;
      default:   exc_code = (acc == ACC_FETCH) ? EX_ADR_FETCH : EX_ADR_MEM;
    endcase
  end

endmodule

// File: rtl/xlat_front.sv
module xlat_front
  import xlat_pkg::*;
#(
  parameter int NWIN     = 4,
  parameter int ADDR_W   = 64,
  parameter int VA_W     = 48,
  parameter int PA_W     = 48,
  parameter int EXT_W    = 16,
  parameter int PG_SHIFT = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_vaddr,
  input  logic [1:0]             req_acc,
  input  logic [1:0]             req_priv,
  input  logic                   mode_da,
  input  logic                   mode_pg,
  input  logic [NWIN*ADDR_W-1:0] win_cfg,
  input  logic                   dbg_hold,
  output logic                   busy,
  output logic                   tlb_req,
  output logic [ADDR_W-1:0]      tlb_vaddr,
  output logic [1:0]             tlb_acc,
  input  logic                   tlb_rsp_valid,
  input  logic [2:0]             tlb_rsp_code,
  input  logic [PA_W-1:0]        tlb_rsp_paddr,
  input  logic [2:0]             tlb_rsp_grant,
  output logic                   done,
  output logic [PA_W-1:0]        pa_out,
  output logic [2:0]             grant,
  output logic                   exc_valid,
  output logic [3:0]             exc_code,
  output logic                   refill_set,
  output logic                   refill_badv_we,
  output logic [ADDR_W-1:0]      refill_badv,
  output logic [VA_W-PG_SHIFT-2:0] refill_vppn,
  output logic                   badv_we,
  output logic [ADDR_W-1:0]      badv,
  output logic                   ehi_we,
  output logic [ADDR_W-1:0]      ehi
);
  localparam int PAIR_LSB = PG_SHIFT + 1;
  localparam int VPPN_W   = VA_W - PAIR_LSB;

  typedef enum logic {S_IDLE, S_WAIT} st_e;
  st_e st;

  logic [ADDR_W-1:0] va_q;
  logic [1:0]        acc_q;

  logic              accept;
  logic [NWIN-1:0]   win_hit;
  logic              win_any;
  logic              direct;
  logic              canon;
  logic [EXT_W-1:0]  ext_bits;
  logic              local_done;
  kind_e             local_kind;

  logic              fin_go;
  kind_e             fin_kind;
  logic [ADDR_W-1:0] fin_va;
  logic [1:0]        fin_acc;
  logic [PA_W-1:0]   fin_pa;
  logic [2:0]        fin_grant;
  logic [3:0]        fin_code;
  logic              fin_fault;
  logic              fin_refill;

  assign accept = (st == S_IDLE) && req_valid;
  assign busy   = (st == S_WAIT);

  xlat_win_match #(
    .NWIN(NWIN), .ADDR_W(ADDR_W), .VA_W(VA_W), .EN_K_BIT(0), .EN_U_BIT(3)
  ) u_win (
    .win_cfg (win_cfg),
    .vaddr   (req_vaddr),
    .priv    (req_priv),
    .hit     (win_hit),
    .hit_any (win_any)
  );

  assign direct   = mode_da & ~mode_pg;
  assign ext_bits = req_vaddr[VA_W +: EXT_W];
  assign canon    = (&ext_bits) | ~(|ext_bits);

  always_comb begin
    local_done = direct | win_any | ~canon;
    local_kind = (direct | win_any) ? K_OK : K_BAD;
  end

  always_comb begin
    if (st == S_WAIT) begin
      fin_go    = tlb_rsp_valid;
      fin_kind  = tlb_to_kind(tlb_rsp_code);
      fin_va    = va_q;
      fin_acc   = acc_q;
      fin_pa    = tlb_rsp_paddr;
      fin_grant = tlb_rsp_grant;
    end else begin
      fin_go    = accept & local_done;
      fin_kind  = local_kind;
      fin_va    = req_vaddr;
      fin_acc   = req_acc;
      fin_pa    = req_vaddr[PA_W-1:0];
      fin_grant = 3'b111;
    end
  end

  xlat_exc_map u_map (
    .kind     (fin_kind),
    .acc      (fin_acc),
    .exc_code (fin_code),
    .fault    (fin_fault),
    .refill   (fin_refill)
  );

  // Sequencer and request port.
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      tlb_req   <= 1'b0;
      tlb_vaddr <= '0;
      tlb_acc   <= '0;
      va_q      <= '0;
      acc_q     <= '0;
    end else begin
      tlb_req <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept && !local_done) begin
            st        <= S_WAIT;
            tlb_req   <= 1'b1;
            tlb_vaddr <= req_vaddr;
            tlb_acc   <= req_acc;
            va_q      <= req_vaddr;
            acc_q     <= req_acc;
          end
        end
        default: begin
          if (tlb_rsp_valid) st <= S_IDLE;
        end
      endcase
    end
  end

  // Registered result and capture strobes.
  always_ff @(posedge clk) begin
    if (rst) begin
      done           <= 1'b0;
      pa_out         <= '0;
      grant          <= '0;
      exc_valid      <= 1'b0;
      exc_code       <= '0;
      refill_set     <= 1'b0;
      refill_badv_we <= 1'b0;
      refill_badv    <= '0;
      refill_vppn    <= '0;
      badv_we        <= 1'b0;
      badv           <= '0;
      ehi_we         <= 1'b0;
      ehi            <= '0;
    end else begin
      done           <= fin_go;
      refill_set     <= 1'b0;
      refill_badv_we <= 1'b0;
      badv_we        <= 1'b0;
      ehi_we         <= 1'b0;
      if (fin_go) begin
        exc_valid <= fin_fault;
        exc_code  <= fin_code;
        pa_out    <= fin_fault ? '0 : fin_pa;
        grant     <= fin_fault ? 3'b000 : fin_grant;
        if (fin_refill) begin
          refill_set     <= 1'b1;
          refill_badv_we <= 1'b1;
          refill_badv    <= fin_va;
          refill_vppn    <= fin_va[PAIR_LSB +: VPPN_W];
        end else if (fin_fault) begin
          ehi_we <= 1'b1;
          ehi    <= {fin_va[ADDR_W-1:PAIR_LSB], {PAIR_LSB{1'b0}}};
          if (!dbg_hold) begin
            badv_we <= 1'b1;
            badv    <= fin_va;
          end
        end
      end
    end
  end

endmodule

// File: rtl/xlat_front_chk.sv
module xlat_front_chk #(
  parameter int PA_W = 48
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            mode_da,
  input logic            mode_pg,
  input logic            busy,
  input logic            tlb_req,
  input logic            done,
  input logic [PA_W-1:0] pa_out,
  input logic [2:0]      grant,
  input logic            exc_valid,
  input logic            refill_set,
  input logic            refill_badv_we,
  input logic            badv_we,
  input logic            ehi_we
);

  // R5
  tlb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tlb_req |=> !tlb_req);

  // R5
  tlb_not_done_chk: assert property (@(posedge clk) disable iff (rst)
    tlb_req |-> !done);

  // R2
  direct_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && mode_da && !mode_pg) |=> (done && grant == 3'b111 && !exc_valid));

  // R10
  fault_nogrant_chk: assert property (@(posedge clk) disable iff (rst)
    (done && exc_valid) |-> (grant == 3'b000 && pa_out == '0));

  // R8
  refill_excl_chk: assert property (@(posedge clk) disable iff (rst)
    refill_badv_we |-> (refill_set && exc_valid && done && !badv_we && !ehi_we));

  // R9
  badv_pair_chk: assert property (@(posedge clk) disable iff (rst)
    badv_we |-> (ehi_we && exc_valid && done && !refill_set));

  // R11
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

endmodule

bind xlat_front xlat_front_chk #(.PA_W(PA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .mode_da        (mode_da),
  .mode_pg        (mode_pg),
  .busy           (busy),
  .tlb_req        (tlb_req),
  .done           (done),
  .pa_out         (pa_out),
  .grant          (grant),
  .exc_valid      (exc_valid),
  .refill_set     (refill_set),
  .refill_badv_we (refill_badv_we),
  .badv_we        (badv_we),
  .ehi_we         (ehi_we)
);

// File: tb/sim_xlat_front.sv
`timescale 1ns/1ps
module sim_xlat_front;
  localparam int NWIN = 4;
  localparam int AW   = 64;
  localparam int VW   = 48;
  localparam int PW   = 48;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst;
  logic            req_valid;
  logic [AW-1:0]   req_vaddr;
  logic [1:0]      req_acc, req_priv;
  logic            mode_da, mode_pg, dbg_hold;
  logic [NWIN*AW-1:0] win_cfg;
  logic            busy, tlb_req;
  logic [AW-1:0]   tlb_vaddr;
  logic [1:0]      tlb_acc;
  logic            tlb_rsp_valid;
  logic [2:0]      tlb_rsp_code;
  logic [PW-1:0]   tlb_rsp_paddr;
  logic [2:0]      tlb_rsp_grant;
  logic            done;
  logic [PW-1:0]   pa_out;
  logic [2:0]      grant;
  logic            exc_valid;
  logic [3:0]      exc_code;
  logic            refill_set, refill_badv_we, badv_we, ehi_we;
  logic [AW-1:0]   refill_badv, badv, ehi;
  logic [VW-14:0]  refill_vppn;

  xlat_front u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_priv(req_priv), .mode_da(mode_da), .mode_pg(mode_pg),
    .win_cfg(win_cfg), .dbg_hold(dbg_hold), .busy(busy), .tlb_req(tlb_req),
    .tlb_vaddr(tlb_vaddr), .tlb_acc(tlb_acc), .tlb_rsp_valid(tlb_rsp_valid),
    .tlb_rsp_code(tlb_rsp_code), .tlb_rsp_paddr(tlb_rsp_paddr),
    .tlb_rsp_grant(tlb_rsp_grant), .done(done), .pa_out(pa_out), .grant(grant),
    .exc_valid(exc_valid), .exc_code(exc_code), .refill_set(refill_set),
    .refill_badv_we(refill_badv_we), .refill_badv(refill_badv),
    .refill_vppn(refill_vppn), .badv_we(badv_we), .badv(badv),
    .ehi_we(ehi_we), .ehi(ehi)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Observed results of one request.
  logic          o_done, o_tlb, o_exc, o_rset, o_rwe, o_bwe, o_ewe;
  logic [3:0]    o_code;
  logic [PW-1:0] o_pa;
  logic [2:0]    o_grant;
  logic [AW-1:0] o_rbadv, o_badv, o_ehi, o_tva;
  logic [VW-14:0] o_vppn;
  logic [1:0]    o_tacc;

  task automatic run_req(input logic [AW-1:0] va, input logic [1:0] acc,
                         input logic [2:0] code, input logic [PW-1:0] tpa,
                         input logic [2:0] tgr);
    o_done = 0; o_tlb = 0;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_acc = acc;
    tlb_rsp_code = code; tlb_rsp_paddr = tpa; tlb_rsp_grant = tgr;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      req_valid = 0;
      tlb_rsp_valid = 0;
      if (tlb_req) begin
        o_tlb = 1; o_tva = tlb_vaddr; o_tacc = tlb_acc;
        tlb_rsp_valid = 1;
      end
      if (done) begin
        o_done = 1; o_exc = exc_valid; o_code = exc_code; o_pa = pa_out;
        o_grant = grant; o_rset = refill_set; o_rwe = refill_badv_we;
        o_bwe = badv_we; o_ewe = ehi_we; o_rbadv = refill_badv;
        o_badv = badv; o_ehi = ehi; o_vppn = refill_vppn;
        break;
      end
    end
    tlb_rsp_valid = 0;
  endtask

  function automatic logic [3:0] exp_code(input int kind, input logic [1:0] acc);
    // kind: 0 ok, 1 bad, 2 nomatch, 3 invalid, 4 dirty, 5 rinh, 6 xinh, 7 priv
    logic [3:0] pi;
    pi = (acc == 2'd1) ? 4'd4 : (acc == 2'd2) ? 4'd5 : 4'd3;
    case (kind)
      0: return 4'd0;
      1: return (acc == 2'd2) ? 4'd1 : 4'd2;
      2, 3: return pi;
      4: return 4'd6;
      5: return 4'd7;
      6: return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  // Full request with model prediction.
  task automatic test(input string tag, input logic [AW-1:0] va, input logic [1:0] acc,
                      input logic [2:0] code);
    bit direct, winhit, canon, via_tlb;
    int kind;
    logic [PW-1:0] tpa;
    logic [PW-1:0] epa;
    logic [2:0] egr;
    tpa = PW'(48'h0ABC_DEF0_1000) ^ PW'(code);
    direct = mode_da && !mode_pg;
    winhit = 0;
    for (int w = 0; w < NWIN; w++) begin
      logic [AW-1:0] wr;
      bit en;
      wr = win_cfg[w*AW +: AW];
      en = (req_priv == 0 && wr[0]) || (req_priv == 3 && wr[3]);
      if (en && wr[63:48] == va[63:48]) winhit = 1;
    end
    canon = (va[63:48] == 16'h0000) || (va[63:48] == 16'hFFFF);
    via_tlb = !direct && !winhit && canon;
    if (direct || winhit) kind = 0;
    else if (!canon) kind = 1;
    else kind = (code == 0) ? 0 : (code == 7) ? 1 : int'(code) + 1;
    if (kind != 0) begin epa = '0; egr = 3'b000; end
    else if (via_tlb) begin epa = tpa; egr = 3'b110; end
    else begin epa = va[PW-1:0]; egr = 3'b111; end
    run_req(va, acc, code, tpa, 3'b110);
    chk({tag, " done"}, o_done, 1'b1);
    chk({tag, " R5 tlb path"}, o_tlb, via_tlb);
    if (via_tlb) begin
      chk({tag, " R5 tlb_vaddr"}, o_tva, va);
      chk({tag, " R5 tlb_acc"}, o_tacc, acc);
    end
    chk({tag, " R10 exc_valid"}, o_exc, kind != 0);
    chk({tag, " R6 R7 exc_code"}, o_code, exp_code(kind, acc));
    chk({tag, " R10 pa_out"}, o_pa, epa);
    chk({tag, " R10 grant"}, o_grant, egr);
    chk({tag, " R8 refill strobes"}, {o_rset, o_rwe}, (kind == 2) ? 2'b11 : 2'b00);
    if (kind == 2) begin
      chk({tag, " R8 refill_badv"}, o_rbadv, va);
      chk({tag, " R8 refill_vppn"}, o_vppn, va[47:13]);
    end
    chk({tag, " R9 ehi_we"}, o_ewe, kind != 0 && kind != 2);
    chk({tag, " R9 badv_we"}, o_bwe, kind != 0 && kind != 2 && !dbg_hold);
    if (kind != 0 && kind != 2) begin
      chk({tag, " R9 ehi"}, o_ehi, {va[63:13], 13'b0});
      if (!dbg_hold) chk({tag, " R9 badv"}, o_badv, va);
    end
  endtask

  initial begin
    rst = 1; req_valid = 0; req_vaddr = '0; req_acc = 0; req_priv = 0;
    mode_da = 0; mode_pg = 1; dbg_hold = 0; win_cfg = '0;
    tlb_rsp_valid = 0; tlb_rsp_code = 0; tlb_rsp_paddr = '0; tlb_rsp_grant = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk("R1 reset outputs",
        {done, busy, tlb_req, exc_valid, refill_set, refill_badv_we, badv_we, ehi_we}, 8'h00);
    rst = 0;

    // R2: every mode combination against a non-canonical address.
    for (int m = 0; m < 4; m++) begin
      mode_da = m[0]; mode_pg = m[1];
      test("R2 mode", 64'h4000_1234_5678_9ABC, 2'd0, 3'd0);
      test("R2 mode", 64'h0000_7FFF_0000_1FFF, 2'd2, 3'd0);
    end
    mode_da = 0; mode_pg = 1;

    // R3: window 2 gating by privilege and enable bits.
    for (int e = 0; e < 4; e++) begin
      win_cfg = '0;
      win_cfg[2*AW +: AW] = {16'h9000, 44'h0, e[1], 2'b00, e[0]};
      for (int p = 0; p < 4; p++) begin
        req_priv = 2'(p);
        test("R3 R4 window", 64'h9000_1234_5678_9ABC, 2'd1, 3'd0);
        test("R3 R4 window", 64'h9000_0000_0000_0001, 2'd2, 3'd0);
      end
    end
    win_cfg = '0; req_priv = 0;

    // R4: sign-extension boundaries.
    test("R4 canon", 64'h0000_7FFF_FFFF_F000, 2'd0, 3'd0);
    test("R4 canon", 64'hFFFF_8000_0000_0000, 2'd2, 3'd0);
    test("R4 canon", 64'h0001_0000_0000_0000, 2'd2, 3'd0);
    test("R4 canon", 64'h8000_0000_0000_0000, 2'd0, 3'd0);
    test("R4 canon", 64'h7FFF_FFFF_FFFF_FFFF, 2'd1, 3'd0);

    // R5-R9: every TLB code, access type and debug hold setting.
    for (int d = 0; d < 2; d++) begin
      dbg_hold = d[0];
      for (int a = 0; a < 4; a++) begin
        for (int c = 0; c < 8; c++) begin
          test("R5 R6 R7 tlb", (a[0] ? 64'hFFFF_8765_4321_3FFF : 64'h0000_1234_5678_ABCD),
               2'(a), 3'(c));
        end
      end
    end
    dbg_hold = 0;

    // R11: request while waiting for the TLB is ignored.
    @(negedge clk);
    req_valid = 1; req_vaddr = 64'h0000_0000_0000_6000; req_acc = 2'd0;
    @(negedge clk);
    chk("R11 tlb_req issued", tlb_req, 1'b1);
    mode_da = 1; mode_pg = 0;
    req_vaddr = 64'h0000_0000_CAFE_0000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 no done while busy", done, 1'b0);
      chk("R11 tlb_vaddr held", tlb_vaddr, 64'h0000_0000_0000_6000);
    end
    req_valid = 0; mode_da = 0; mode_pg = 1;
    tlb_rsp_code = 3'd1; tlb_rsp_valid = 1;
    @(negedge clk);
    tlb_rsp_valid = 0;
    chk("R11 first completes", done, 1'b1);
    chk("R11 R8 refill_badv of first", refill_badv, 64'h0000_0000_0000_6000);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 no second completion", done, 1'b0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule